// File: doc/BRIEF.md
# Nine-Valued Edge-Triggered Register Bank

This block is a register bank of parameterised width whose clock, reset and data lines each carry one of nine logic levels. Each level travels as a 4-bit code: U=0, X=1, 0=2, 1=3, Z=4, W=5, L=6, H=7, don't-care=8. A free-running system clock samples all encoded lines on every cycle. The block folds each line into one of four classes: U, X, 0 or 1. It tracks the class the encoded clock had on the previous cycle, and from the previous and present clock classes it names the clock change. It then updates every stored bit according to that change, the reset class and the data class.

The block lets a digital design mimic a multi-valued flip-flop bank. Unknowns entering on the clock, the reset or the data stay visible at the outputs and are not silently resolved. A parameter picks whether the encoded reset is active high or active low. Outputs carry only the codes for U, X, 0 and 1. A change on the inputs that are sampled at one system clock edge appears on the outputs right after that edge.

Named clock changes, with the previous class followed by the present class:
- RISE is 0→1.
- UNKNOWN is 0→X, 0→U, X→1 or U→1.
- IDLE is every other pair: no change, 1→anything, X→X/U, U→X/U and U/X→0.

Named reset modes:
- POISON is a reset class of U.
- CLEAR is an asserted reset.
- BLUR is a reset class of X.
- RUN is an inactive reset.

Top module: `nvreg_edge`

## Requirements
- R1: Each 4-bit code folds into a class. Code 0 gives U. Codes 2 (0) and 6 (L) give 0. Codes 3 (1) and 7 (H) give 1. Codes 1 (X), 4 (Z), 5 (W), 8 (don't-care) and the unused codes 9 to 15 give X.
- R2: In RUN, a RISE clock change loads every bit with its data class. The output code is 0 for U, 1 for X, 2 for 0 and 3 for 1, and it shows after the system edge that sampled the change.
- R3: In RUN, an IDLE clock change leaves every output bit unchanged, whatever the data lines carry.
- R4: In RUN, an UNKNOWN clock change works per bit. A stored 0 or 1 stays if the data class equals it. A stored U stays U. Every other bit becomes X.
- R5: A reset class of U (POISON) sets every output bit to U after the next system edge, whatever the clock and data do.
- R6: An asserted reset (CLEAR) sets every output bit to 0 after the next system edge, with no clock change needed. With RST_HIGH=1, class 1 asserts and class 0 is inactive. With RST_HIGH=0 these are swapped.
- R7: A reset class of X (BLUR) works per bit. A stored 0 stays 0. A stored U stays U. Every other bit becomes X, whatever the clock does.
- R8: While rst_ni is low, every output bit holds U and the remembered clock class is U. So the first clock class seen after release is compared against U.
- R9: Every output nibble is always one of the codes 0 to 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | System reset, active low; sets the power-up state |
| clk_code_i | input | 4 | Encoded nine-valued clock line |
| rst_code_i | input | 4 | Encoded nine-valued reset line |
| din_i | input | 4*WIDTH | Encoded data lines; nibble k is bit k |
| dout_o | output | 4*WIDTH | Encoded outputs; nibble k is bit k, codes 0 to 3 only |

## Verification
The assertions assume that the encoded lines are stable around each system clock edge. They also assume that the system reset is held for at least one edge before any encoded activity counts, since the clock-change checks only apply once a full cycle has passed outside reset. The bench changes every encoded input half a period away from the sampling edge. It holds rst_ni low for several edges at start-up. The random stimulus covers all sixteen 4-bit codes on the data lines and all nine levels on the clock and reset lines. It is biased toward 0 and 1 clock levels and an inactive reset, so that the RISE, UNKNOWN and IDLE changes all occur many times.

// File: rtl/nv9_pkg.sv
package nv9_pkg;

    // Four-way class of a nine-valued level; the value equals the output code
    typedef enum logic [1:0] {
        CL_U = 2'd0,
        CL_X = 2'd1,
        CL_0 = 2'd2,
        CL_1 = 2'd3
    } cls_t;

    // Named change of the encoded clock between two samples
    typedef enum logic [1:0] {
        TR_IDLE = 2'd0,
        TR_RISE = 2'd1,
        TR_UNK  = 2'd2
    } trans_t;

    // Reset line interpretation
    typedef enum logic [1:0] {
        RM_RUN    = 2'd0,
        RM_CLEAR  = 2'd1,
        RM_POISON = 2'd2,
        RM_BLUR   = 2'd3
    } rmode_t;

    localparam int unsigned CODE_W = 4;

    localparam logic [CODE_W-1:0] LV_U  = 4'd0;
    localparam logic [CODE_W-1:0] LV_X  = 4'd1;
    localparam logic [CODE_W-1:0] LV_0  = 4'd2;
    localparam logic [CODE_W-1:0] LV_1  = 4'd3;
    localparam logic [CODE_W-1:0] LV_Z  = 4'd4;
    localparam logic [CODE_W-1:0] LV_W  = 4'd5;
    localparam logic [CODE_W-1:0] LV_L  = 4'd6;
    localparam logic [CODE_W-1:0] LV_H  = 4'd7;
    localparam logic [CODE_W-1:0] LV_DC = 4'd8;

    function automatic cls_t fold9(input logic [CODE_W-1:0] code);
        cls_t r;
        case (code)
            LV_U:       r = CL_U;
            LV_0, LV_L: r = CL_0;
            LV_1, LV_H: r = CL_1;
            default:    r = CL_X;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/nv9_fold.sv
module nv9_fold
    import nv9_pkg::*;
#(
    parameter int unsigned N = 1
) (
    input  logic [N*CODE_W-1:0] codes_i,
    output logic [N*2-1:0]      cls_o
);

    for (genvar k = 0; k < N; k++) begin : g_lane
        cls_t c;
        always_comb c = fold9(codes_i[k*CODE_W +: CODE_W]);
        assign cls_o[k*2 +: 2] = c;
    end

endmodule

// File: rtl/nv9_clk_track.sv
module nv9_clk_track
    import nv9_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  cls_t   cur_i,
    output trans_t trans_o
);

    cls_t prev_q;

    // State register: class of the encoded clock on the previous sample
    always_ff @(posedge clk_i) begin
        if (!rst_ni) prev_q <= CL_U;
        else         prev_q <= cur_i;
    end

    // Transition naming
    always_comb begin
        trans_o = TR_IDLE;
        unique case (prev_q)
            CL_0: begin
                if (cur_i == CL_1)                         trans_o = TR_RISE;
                else if (cur_i == CL_X || cur_i == CL_U)   trans_o = TR_UNK;
                else                                       trans_o = TR_IDLE;
            end
            CL_X, CL_U: begin
                if (cur_i == CL_1) trans_o = TR_UNK;
                else               trans_o = TR_IDLE;
            end
            CL_1: trans_o = TR_IDLE;
        endcase
    end

endmodule

// File: rtl/nv9_rst_decode.sv
module nv9_rst_decode
    import nv9_pkg::*;
#(
    parameter bit RST_HIGH = 1'b1
) (
    input  cls_t   rcls_i,
    output rmode_t mode_o
);

    localparam cls_t ACT_CLS = RST_HIGH ? CL_1 : CL_0;

    always_comb begin
        mode_o = RM_RUN;
        unique case (rcls_i)
            CL_U:       mode_o = RM_POISON;
            CL_X:       mode_o = RM_BLUR;
            CL_0, CL_1: mode_o = (rcls_i == ACT_CLS) ? RM_CLEAR : RM_RUN;
        endcase
    end

endmodule

// File: rtl/nv9_bit_cell.sv
module nv9_bit_cell
    import nv9_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  rmode_t mode_i,
    input  trans_t trans_i,
    input  cls_t   d_i,
    output cls_t   q_o
);

    cls_t q_q, q_d;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q_q <= CL_U;
        else         q_q <= q_d;
    end

    always_comb begin
        q_d = q_q;
        unique case (mode_i)
            RM_POISON: q_d = CL_U;
            RM_CLEAR:  q_d = CL_0;
            RM_BLUR: begin
                if (q_q == CL_0 || q_q == CL_U) q_d = q_q;
                else                            q_d = CL_X;
            end
            RM_RUN: begin
                unique case (trans_i)
                    TR_RISE: q_d = d_i;
                    TR_UNK: begin
                        if (q_q == CL_U)                                   q_d = CL_U;
                        else if ((q_q == CL_0 || q_q == CL_1) && d_i == q_q) q_d = q_q;
                        else                                               q_d = CL_X;
                    end
                    default: q_d = q_q;
                endcase
            end
        endcase
    end

    assign q_o = q_q;

endmodule

// File: rtl/nvreg_edge.sv
module nvreg_edge
    import nv9_pkg::*;
#(
    parameter int unsigned WIDTH    = 8,
    parameter bit          RST_HIGH = 1'b1
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [3:0]            clk_code_i,
    input  logic [3:0]            rst_code_i,
    input  logic [WIDTH*4-1:0]    din_i,
    output logic [WIDTH*4-1:0]    dout_o
);

    localparam int unsigned DW = WIDTH * CODE_W;

    logic [1:0]       ck_cls_raw, rs_cls_raw;
    logic [WIDTH*2-1:0] d_cls_raw;
    trans_t           trans;
    rmode_t           mode;

    nv9_fold #(.N(1)) u_fold_ck (.codes_i(clk_code_i), .cls_o(ck_cls_raw));
    nv9_fold #(.N(1)) u_fold_rs (.codes_i(rst_code_i), .cls_o(rs_cls_raw));
    nv9_fold #(.N(WIDTH)) u_fold_d (.codes_i(din_i[DW-1:0]), .cls_o(d_cls_raw));

    nv9_clk_track u_track (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cur_i  (cls_t'(ck_cls_raw)),
        .trans_o(trans)
    );

    nv9_rst_decode #(.RST_HIGH(RST_HIGH)) u_rdec (
        .rcls_i(cls_t'(rs_cls_raw)),
        .mode_o(mode)
    );

    for (genvar k = 0; k < WIDTH; k++) begin : g_bit
        cls_t q;
        nv9_bit_cell u_cell (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .mode_i (mode),
            .trans_i(trans),
            .d_i    (cls_t'(d_cls_raw[k*2 +: 2])),
            .q_o    (q)
        );
        assign dout_o[k*CODE_W +: CODE_W] = {2'b00, q};
    end

endmodule

// File: rtl/nvreg_edge_chk.sv
module nvreg_edge_chk
    import nv9_pkg::*;
#(
    parameter int unsigned WIDTH    = 8,
    parameter bit          RST_HIGH = 1'b1
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [3:0]         clk_code_i,
    input logic [3:0]         rst_code_i,
    input logic [WIDTH*4-1:0] din_i,
    input logic [WIDTH*4-1:0] dout_o
);

    localparam cls_t ACT_CLS = RST_HIGH ? CL_1 : CL_0;
    localparam cls_t OFF_CLS = RST_HIGH ? CL_0 : CL_1;
    localparam logic [WIDTH*4-1:0] ALL_ZERO_LVL = {WIDTH{4'd2}};

    logic armed;
    always_ff @(posedge clk_i) begin
        if (!rst_ni) armed <= 1'b0;
        else         armed <= 1'b1;
    end

    logic [WIDTH*4-1:0] d_reduced;
    logic               out_bad;
    always_comb begin
        out_bad = 1'b0;
        for (int k = 0; k < WIDTH; k++) begin
            d_reduced[k*4 +: 4] = {2'b00, fold9(din_i[k*4 +: 4])};
            if (dout_o[k*4+2 +: 2] != 2'b00) out_bad = 1'b1;
        end
    end

    // R9: only U/X/0/1 codes leave the block
    a_r9_legal_codes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !out_bad);

    // R8: system reset gives all-U outputs
    a_r8_power_up_u: assert property (@(posedge clk_i)
        !rst_ni |=> dout_o == '0);

    // R5: reset class U poisons every bit
    a_r5_poison: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fold9(rst_code_i) == CL_U |=> dout_o == '0);

    // R6: asserted reset clears without a clock change
    a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fold9(rst_code_i) == ACT_CLS |=> dout_o == ALL_ZERO_LVL);

    // R2: rising clock loads the reduced data
    a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed && fold9(rst_code_i) == OFF_CLS && fold9($past(clk_code_i)) == CL_0
         && fold9(clk_code_i) == CL_1) |=> dout_o == $past(d_reduced));

    // R3: a clock that stays at 1 keeps the word
    a_r3_hold_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed && fold9(rst_code_i) == OFF_CLS && fold9($past(clk_code_i)) == CL_1)
        |=> $stable(dout_o));

endmodule

bind nvreg_edge nvreg_edge_chk #(.WIDTH(WIDTH), .RST_HIGH(RST_HIGH)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clk_code_i(clk_code_i),
    .rst_code_i(rst_code_i),
    .din_i     (din_i),
    .dout_o    (dout_o)
);

// File: tb/nvreg_edge_bench.sv
module nvreg_edge_bench;

    localparam int W = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [3:0]    ck_code, rs_code, rs_code_lo;
    logic [W*4-1:0] din;
    logic [W*4-1:0] dout_hi, dout_lo;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // Class values: U=0 X=1 0=2 1=3
    logic [1:0] exp_q [W];
    logic [1:0] exp_prev;

    always #5 clk = ~clk;

    nvreg_edge #(.WIDTH(W), .RST_HIGH(1'b1)) u_nvreg_edge (
        .clk_i(clk), .rst_ni(rst_n), .clk_code_i(ck_code), .rst_code_i(rs_code),
        .din_i(din), .dout_o(dout_hi));

    nvreg_edge #(.WIDTH(W), .RST_HIGH(1'b0)) u_nvreg_edge_lo (
        .clk_i(clk), .rst_ni(rst_n), .clk_code_i(ck_code), .rst_code_i(rs_code_lo),
        .din_i(din), .dout_o(dout_lo));

    function automatic logic [1:0] cls(input logic [3:0] c);
        case (c)
            4'd0:       return 2'd0;
            4'd2, 4'd6: return 2'd2;
            4'd3, 4'd7: return 2'd3;
            default:    return 2'd1;
        endcase
    endfunction

    // Swap the meaning of 0/1 levels for the active-low copy
    function automatic logic [3:0] flip_lvl(input logic [3:0] c);
        case (c)
            4'd2: return 4'd3;
            4'd3: return 4'd2;
            4'd6: return 4'd7;
            4'd7: return 4'd6;
            default: return c;
        endcase
    endfunction

    // 0 idle, 1 rise, 2 unknown
    function automatic int kind(input logic [1:0] p, input logic [1:0] c);
        if (p == 2'd2 && c == 2'd3) return 1;
        if (p == 2'd2 && c <= 2'd1) return 2;
        if (p <= 2'd1 && c == 2'd3) return 2;
        return 0;
    endfunction

    function automatic logic [1:0] nxt(input logic [1:0] q, input logic [1:0] r,
                                       input int t, input logic [1:0] d);
        if (r == 2'd0) return 2'd0;
        if (r == 2'd3) return 2'd2;
        if (r == 2'd1) return (q == 2'd2 || q == 2'd0) ? q : 2'd1;
        if (t == 1) return d;
        if (t == 2) begin
            if (q == 2'd0) return 2'd0;
            if ((q == 2'd2 || q == 2'd3) && d == q) return q;
            return 2'd1;
        end
        return q;
    endfunction

    function automatic logic [W*4-1:0] exp_word();
        logic [W*4-1:0] w;
        for (int k = 0; k < W; k++) w[k*4 +: 4] = {2'b00, exp_q[k]};
        return w;
    endfunction

    task automatic check(input string req);
        logic [W*4-1:0] e;
        e = exp_word();
        tests++;
        if (dout_hi !== e) begin
            fails++;
            $display("FAIL %s high-active: got %h expected %h", req, dout_hi, e);
        end
        tests++;
        if (dout_lo !== e) begin
            fails++;
            $display("FAIL %s low-active: got %h expected %h", req, dout_lo, e);
        end
    endtask

    // Called at a falling edge: drive, update model, pass the sampling edge, check
    task automatic step(input logic [3:0] cc, input logic [3:0] rc,
                        input logic [W*4-1:0] d, input string req);
        int t;
        ck_code = cc; rs_code = rc; rs_code_lo = flip_lvl(rc); din = d;
        t = kind(exp_prev, cls(cc));
        for (int k = 0; k < W; k++) exp_q[k] = nxt(exp_q[k], cls(rc), t, cls(d[k*4 +: 4]));
        exp_prev = cls(cc);
        @(posedge clk);
        @(negedge clk);
        check(req);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [W*4-1:0] rd;
        logic [3:0] rcc, rrc;
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed_1234);
        rst_n = 1'b0; ck_code = 4'd2; rs_code = 4'd2; rs_code_lo = 4'd3; din = '0;
        for (int k = 0; k < W; k++) exp_q[k] = 2'd0;
        exp_prev = 2'd0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R8 reset state all U");
        rst_n = 1'b1;

        step(4'd2, 4'd2, 32'h33333333, "R8 first sample U->0 idle");
        step(4'd3, 4'd2, 32'h33333333, "R4 U->... no; 0->1 rise of all ones (R2)");
        step(4'd2, 4'd2, 32'h22222222, "R3 fall holds");
        step(4'd7, 4'd6, 32'h76543210, "R1 R2 rise via H loads folded mix");
        step(4'd6, 4'd2, 32'h22222222, "R3 fall via L holds");
        step(4'd6, 4'd6, 32'h33333333, "R3 steady 0 holds");
        step(4'd1, 4'd2, 32'h73672233, "R4 0->X unknown edge");
        step(4'd3, 4'd2, 32'h22222222, "R4 X->1 unknown edge");
        step(4'd5, 4'd2, 32'h33333333, "R3 1->W idle");
        step(4'd0, 4'd2, 32'h33333333, "R3 X->U idle");
        step(4'd7, 4'd2, 32'h33333333, "R4 U->H unknown edge");
        step(4'd7, 4'd3, 32'h33333333, "R6 asserted reset clears without edge");
        step(4'd2, 4'd7, 32'h33333333, "R6 asserted reset H level");
        step(4'd3, 4'd2, 32'h30213021, "R2 rise loads 0/1/X/U pattern");
        step(4'd3, 4'd5, 32'h22222222, "R7 reset W blurs 1s, keeps 0 and U");
        step(4'd2, 4'd2, 32'h22222222, "R3 idle after blur");
        step(4'd4, 4'd2, 32'h22222222, "R4 0->Z unknown edge");
        step(4'd2, 4'd0, 32'h33333333, "R5 reset U poisons");
        step(4'd3, 4'd2, 32'hf9a3b2c6, "R1 R9 codes above 8 fold to X");

        for (int i = 0; i < 600; i++) begin
            int r;
            r = $urandom % 10;
            rcc = (r < 4) ? 4'd2 : (r < 8) ? 4'd3 : 4'($urandom % 9);
            r = $urandom % 20;
            if (r == 0)      rrc = ($urandom % 2) ? 4'd3 : 4'd7;
            else if (r == 1) rrc = 4'd0;
            else if (r == 2) rrc = 4'($urandom % 9);
            else             rrc = ($urandom % 2) ? 4'd2 : 4'd6;
            for (int k = 0; k < W; k++)
                rd[k*4 +: 4] = (($urandom % 8) == 0) ? 4'($urandom % 16) : 4'($urandom % 9);
            step(rcc, rrc, rd, "R2 R3 R4 R5 R6 R7 R9 random");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule